// File: doc/BRIEF.md
# Received Signal Strength Energy Detector

This block decides whether the channel carries energy. It compares each received signal strength sample against a programmable threshold. The result is a registered energy-detect flag that the clear channel assessment logic downstream consumes. Each sample arrives as a 6-bit value with a one-cycle valid strobe. The flag is recomputed only on cycles where that strobe is high.

The threshold sits in an 8-bit register with a byte-wide write port and a combinational read port. The low six bits hold the threshold. The upper two bits are spare storage: they can be written and read back, but they do not affect detection. Detection requires the sample to be strictly greater than the threshold. A threshold of all ones therefore turns detection off, and the register comes out of reset with that value.

Top module: `rssi_energy_detect`

## Requirements
- R1: While reset is active and in the first cycle after it, the register reads 8'h3F and energyDetect is 0.
- R2: A write with regWrEn high stores all eight bits of regWrData, and regRdData returns them from the next cycle onward.
- R3: Bits 7:6 of the register have no effect on energyDetect. Only bits 5:0 form the threshold.
- R4: On a cycle with rssiValid high, energyDetect takes the value (rssiValue > threshold) at that clock edge. The result is visible one cycle after the strobe.
- R5: When rssiValue equals the threshold, energyDetect is 0 after the strobe.
- R6: On cycles with rssiValid low, energyDetect keeps its previous value.
- R7: With a threshold of 6'h3F, energyDetect is 0 after every strobe, whatever the sample.
- R8: When a write and a strobe occur in the same cycle, the comparison uses the threshold held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| rssiValid | input | 1 | Sample valid strobe |
| rssiValue | input | 6 | Signal strength sample |
| energyDetect | output | 1 | Registered energy-detect flag |

## Verification
The assertions check on every cycle that the flag follows the strict comparison against the pre-write threshold after each strobe. They also check that the flag holds between strobes, that a write is read back on the next cycle, and that an all-ones threshold keeps the flag low. Some behaviours can only be shown by the bench's scenarios, which are built from chosen values. These are the equal-value boundary, the spare bits being ignored (same samples, different upper bits), a same-cycle write and strobe, and the flag falling and rising across threshold changes.

// File: rtl/rssi_ed_pkg.sv
package rssi_ed_pkg;
  parameter int RSSI_W = 6;
  parameter int REG_W  = 8;
  localparam int SPARE_W = REG_W - RSSI_W;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReg;
    logic evalSample;
  } edStrobes_t;
endpackage

// File: rtl/rssi_ed_ctrl.sv
module rssi_ed_ctrl
  import rssi_ed_pkg::*;
(
  input  logic       regWrEn,
  input  logic       rssiValid,
  output edStrobes_t strobes
);
  always_comb begin
    strobes.loadReg    = regWrEn;
    strobes.evalSample = rssiValid;
  end
endmodule

// File: rtl/rssi_ed_datapath.sv
module rssi_ed_datapath
  import rssi_ed_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int SW = RSSI_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  edStrobes_t    strobes,
  input  logic [DW-1:0] wrData,
  input  logic [SW-1:0] sample,
  output logic [DW-1:0] rdData,
  output logic          detect
);
  localparam logic [DW-1:0] RESET_VAL = DW'({SW{1'b1}});

  logic [DW-1:0] cfgReg;
  logic [SW-1:0] threshold;
  logic          aboveThresh;

  assign threshold   = cfgReg[SW-1:0];
  assign aboveThresh = sample > threshold;
  assign rdData      = cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= RESET_VAL;
    end else if (strobes.loadReg) begin
      cfgReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detect <= 1'b0;
    end else if (strobes.evalSample) begin
      detect <= aboveThresh;
    end
  end
endmodule

// File: rtl/rssi_energy_detect.sv
module rssi_energy_detect
  import rssi_ed_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              rssiValid,
  input  logic [RSSI_W-1:0] rssiValue,
  output logic              energyDetect
);
  edStrobes_t strobes;

  rssi_ed_ctrl ctrl_i (
    .regWrEn   (regWrEn),
    .rssiValid (rssiValid),
    .strobes   (strobes)
  );

  rssi_ed_datapath #(.DW(REG_W), .SW(RSSI_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (regWrData),
    .sample  (rssiValue),
    .rdData  (regRdData),
    .detect  (energyDetect)
  );
endmodule

// File: rtl/rssi_energy_detect_checker.sv
module rssi_energy_detect_checker
  import rssi_ed_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_W-1:0]  regWrData,
  input logic [REG_W-1:0]  regRdData,
  input logic              rssiValid,
  input logic [RSSI_W-1:0] rssiValue,
  input logic              energyDetect
);
  localparam logic [RSSI_W-1:0] ALL_ONES = '1;

  assert_reset_value_R1: assert property (@(posedge clk)
    !rstN |=> (regRdData == REG_W'(ALL_ONES) && !energyDetect));

  assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == $past(regWrData));

  // covers R4, R5 and R8: old threshold at the strobe edge
  assert_compare_R4: assert property (@(posedge clk) disable iff (!rstN)
    rssiValid |=> energyDetect == ($past(rssiValue) > $past(regRdData[RSSI_W-1:0])));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rssiValid |=> $stable(energyDetect));

  assert_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rssiValid && regRdData[RSSI_W-1:0] == ALL_ONES) |=> !energyDetect);
endmodule

bind rssi_energy_detect rssi_energy_detect_checker chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regWrData    (regWrData),
  .regRdData    (regRdData),
  .rssiValid    (rssiValid),
  .rssiValue    (rssiValue),
  .energyDetect (energyDetect)
);

// File: tb/rssi_energy_detect_tb_top.sv
module rssi_energy_detect_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       rssiValid = 1'b0;
  logic [5:0] rssiValue = '0;
  logic       energyDetect;

  int checks = 0;
  int fails = 0;
  logic [7:0] shadowReg = 8'h3F;
  logic expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rssi_energy_detect dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .rssiValid(rssiValid), .rssiValue(rssiValue),
    .energyDetect(energyDetect)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per strobe, one cycle later
  always @(posedge clk) begin
    if (rstN && rssiValid) begin
      #1;
      if (expQ.size() > 0) begin
        logic e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {7'b0, energyDetect}, {7'b0, e});
      end
    end
  end

  task automatic writeReg(logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    shadowReg = d;
  endtask

  task automatic sendSample(logic [5:0] v, string tag);
    @(negedge clk);
    rssiValid = 1'b1; rssiValue = v;
    expQ.push_back(v > shadowReg[5:0]);
    tagQ.push_back(tag);
    @(negedge clk);
    rssiValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reg", regRdData, 8'h3F);
    check("R1 ed", {7'b0, energyDetect}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reg after release", regRdData, 8'h3F);

    // R7: disabled at reset value
    sendSample(6'h3F, "R7 max sample");
    sendSample(6'h20, "R7 mid sample");

    // R2 readback including spare bits
    writeReg(8'hD5);
    check("R2 readback", regRdData, 8'hD5);
    writeReg(8'h10);
    check("R2 readback", regRdData, 8'h10);

    // R4 / R5
    sendSample(6'h11, "R4 above");
    sendSample(6'h10, "R5 equal");
    sendSample(6'h3F, "R4 max above");
    sendSample(6'h00, "R4 zero below");

    // R6 hold: set flag, then idle
    sendSample(6'h30, "R4 set");
    repeat (4) @(negedge clk);
    check("R6 hold high", {7'b0, energyDetect}, 8'h01);
    rssiValue = 6'h00;
    repeat (2) @(negedge clk);
    check("R6 hold ignores value", {7'b0, energyDetect}, 8'h01);

    // R3: same threshold, different spare bits
    writeReg(8'hC8);
    sendSample(6'h09, "R3 spare set above");
    sendSample(6'h08, "R3 spare set equal");
    writeReg(8'h08);
    sendSample(6'h09, "R3 spare clear above");
    sendSample(6'h08, "R3 spare clear equal");
    writeReg(8'hBF);
    sendSample(6'h3F, "R3 R7 disabled with spare");
    writeReg(8'h3F);
    sendSample(6'h3E, "R7 below max");

    // R8: write and strobe in the same cycle
    writeReg(8'h05);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = 8'h3F;
    rssiValid = 1'b1; rssiValue = 6'h20;
    expQ.push_back(1'b1); tagQ.push_back("R8 old threshold used");
    @(negedge clk);
    regWrEn = 1'b0; rssiValid = 1'b0; shadowReg = 8'h3F;
    check("R8 new value stored", regRdData, 8'h3F);
    sendSample(6'h20, "R8 new threshold next");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 8'(expQ.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule